// File: doc/BRIEF.md
# Receiver-Aligned Synchronous Transmitter

This block is the transmit half of a byte-oriented synchronous link whose character framing is slaved to the local receiver. After reset it sits quiet and drives a constant line level, either all ones or all zeros as configured, for as long as the receiver is still searching for sync. When the receiver reports that it has found sync, it sends a one-cycle hunt-exit pulse. The transmitter then waits one sync-character time and starts sending the configured sync pattern. Its character boundaries therefore coincide with the receiver's.

After alignment the transmitter runs on its own. It sends one queued data byte after each character boundary when a byte is waiting, and fills every other character slot with the sync pattern, so the character boundary is never lost. Bytes enter through a valid/ready handshake into a one-entry holding register, and may be queued before alignment. The transmit clock is assumed to share rate and phase with the receive clock. The configuration inputs are assumed stable from the hunt-exit pulse onward.

Top module: `rxlock_sync_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, `txd_o` equals `cfg_idle_ones_i` and `tx_ready_o` is 1.
- R2: Until a hunt-exit pulse is accepted, `txd_o` follows `cfg_idle_ones_i` (1 gives constant ones, 0 gives constant zeros), even when a data byte is queued.
- R3: A hunt-exit pulse sampled while hunting makes the first sync bit appear on `txd_o` exactly L clock cycles later, where L is the sync length. During those L cycles the line keeps its idle level.
- R4: The sync length L comes from `cfg_sync_len_i`: code 0 gives 6 bits, code 1 gives 8 bits, code 2 gives 16 bits, and code 3 gives 8 bits.
- R5: The first character after alignment is always the sync pattern: the low L bits of `cfg_sync_pat_i`, sent bit 0 first, one bit per clock.
- R6: A queued data byte is sent as 8 bits, bit 0 first, starting in the cycle right after the last bit of the previous character.
- R7: At every character boundary with no byte held, another sync character is sent. Characters follow each other with no gap cycles.
- R8: Once a hunt-exit pulse has been accepted, later hunt-exit pulses have no effect on the output stream until reset.
- R9: `tx_ready_o` is 1 exactly when no byte is held. A byte is taken when `tx_valid_i` and `tx_ready_o` are both 1 at a clock edge. A valid byte offered while `tx_ready_o` is 0 is dropped, and every accepted byte is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock, same rate and phase as the receive clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cfg_idle_ones_i | input | 1 | Idle line level while hunting: 1 for ones, 0 for zeros |
| cfg_sync_len_i | input | 2 | Sync length code (0: 6, 1: 8, 2: 16, 3: 8 bits) |
| cfg_sync_pat_i | input | 16 | Sync pattern, bit 0 sent first |
| hunt_exit_i | input | 1 | One-cycle pulse from the receiver on sync acquisition |
| tx_data_i | input | 8 | Data byte to queue |
| tx_valid_i | input | 1 | Data byte offered |
| tx_ready_o | output | 1 | Holding register empty, byte can be taken |
| txd_o | output | 1 | Serial data output |

## Verification
The bench measures the delay from hunt-exit to the first sync bit for every length code, including the spare code. A design that counts L-1 or L+1 cycles, or maps the spare code to the wrong length, would shift the whole stream, and the bit-by-bit comparison catches it. Further hunt-exit pulses are fired during the wait and again during the run: a design that restarts its delay on them would open a gap or break a character in two. Mixed 6-bit sync with 8-bit data, back-to-back bytes and a byte offered while the register is full show whether boundaries stay contiguous and whether any byte is lost or sent twice.

// File: rtl/rxlock_sync_pkg.sv
// Package: shared types and constants for the receiver-aligned transmitter.
// Assumes the widest sync pattern is 16 bits and data characters are 8 bits.
package rxlock_sync_pkg;

    localparam int PKG_SYNC_W = 16;
    localparam int PKG_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    // Purpose: map the sync length code to a bit count.
    function automatic int unsigned sync_len_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6;
            2'd2:    return 16;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/rxlock_tx_hold.sv
// Module: one-entry holding register for outgoing data bytes.
// It takes a byte when it is empty and a byte is offered. It empties when the
// shifter loads the byte. Push and pop never coincide, because a push needs an
// empty register and a pop needs a full one.
module rxlock_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic              ready_o,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: track occupancy and capture accepted bytes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (pop_i) begin
            full_q <= 1'b0;
        end else if (push_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= push_data_i;
        end
    end

    assign ready_o = !full_q;
    assign full_o  = full_q;
    assign data_o  = data_q;

endmodule

// File: rtl/rxlock_tx_shift.sv
// Module: variable-length character shifter, LSB first.
// A load sets the word and its length. While enabled, each clock moves out one
// bit. last_o marks the final bit of the current character. Assumes every
// length loaded is at least 1.
module rxlock_tx_shift #(
    parameter int SHIFT_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               load_i,
    input  logic [SHIFT_W-1:0] load_word_i,
    input  logic [CNT_W-1:0]   load_len_i,
    output logic               bit_o,
    output logic               last_o
);

    logic [SHIFT_W-1:0] sh_q;
    logic [CNT_W-1:0]   len_q;
    logic [CNT_W-1:0]   idx_q;

    // Purpose: load a new character or advance one bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q  <= '0;
            len_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= load_word_i;
            len_q <= load_len_i;
            idx_q <= '0;
        end else if (en_i) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (idx_q == (len_q - 1'b1));

endmodule

// File: rtl/rxlock_align_fsm.sv
// Module: alignment controller.
// It hunts until the receiver pulses hunt_exit_i, then counts one sync length
// of clocks and requests the first (sync) load. From then on it requests a
// load at each character end. It never returns to hunting without a reset.
module rxlock_align_fsm
    import rxlock_sync_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hunt_exit_i,
    input  logic [CNT_W-1:0] sync_len_i,
    input  logic             char_last_i,
    output logic             load_o,
    output logic             force_sync_o,
    output logic             waiting_o,
    output logic             running_o
);

    tx_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: hunt, then wait one character time, then run until reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_HUNT: begin
                    if (hunt_exit_i) begin
                        st_q  <= ST_WAIT;
                        cnt_q <= sync_len_i - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q <= ST_RUN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign waiting_o    = (st_q == ST_WAIT);
    assign running_o    = (st_q == ST_RUN);
    assign force_sync_o = waiting_o;
    assign load_o       = (waiting_o && (cnt_q == '0)) || (running_o && char_last_i);

endmodule

// File: rtl/rxlock_sync_tx.sv
// Module: top of the receiver-aligned synchronous transmitter.
// It joins the alignment controller, the holding register and the shifter,
// and picks sync or data at each character boundary. Assumes the transmit
// clock matches the receive clock in rate and phase, and that the
// configuration stays stable from hunt-exit onward.
module rxlock_sync_tx
    import rxlock_sync_pkg::*;
#(
    parameter int DATA_W = PKG_DATA_W,
    parameter int SYNC_W = PKG_SYNC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_idle_ones_i,
    input  logic [1:0]        cfg_sync_len_i,
    input  logic [SYNC_W-1:0] cfg_sync_pat_i,
    input  logic              hunt_exit_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              txd_o
);

    localparam int CNT_W = $clog2(SYNC_W + 1);
    localparam logic [CNT_W-1:0] DATA_LEN = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  sync_len;
    logic              load_w, force_sync_w, wait_w, run_w, last_w, bit_w;
    logic              hold_full, pop_w;
    logic [DATA_W-1:0] hold_data;
    logic [SYNC_W-1:0] data_word, load_word;
    logic [CNT_W-1:0]  load_len;

    assign sync_len = CNT_W'(sync_len_bits(cfg_sync_len_i));

    // Purpose: widen a data byte to the shifter width.
    if (SYNC_W > DATA_W) begin : g_pad
        assign data_word = {{(SYNC_W - DATA_W){1'b0}}, hold_data};
    end else begin : g_nopad
        assign data_word = SYNC_W'(hold_data);
    end

    // Purpose: choose the next character, sync unless a byte is held and sync is not forced.
    always_comb begin
        if (force_sync_w || !hold_full) begin
            load_word = cfg_sync_pat_i;
            load_len  = sync_len;
        end else begin
            load_word = data_word;
            load_len  = DATA_LEN;
        end
    end

    assign pop_w = load_w && !force_sync_w && hold_full;

    rxlock_align_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hunt_exit_i  (hunt_exit_i),
        .sync_len_i   (sync_len),
        .char_last_i  (last_w),
        .load_o       (load_w),
        .force_sync_o (force_sync_w),
        .waiting_o    (wait_w),
        .running_o    (run_w)
    );

    rxlock_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (tx_valid_i),
        .push_data_i (tx_data_i),
        .pop_i       (pop_w),
        .ready_o     (tx_ready_o),
        .full_o      (hold_full),
        .data_o      (hold_data)
    );

    rxlock_tx_shift #(.SHIFT_W(SYNC_W), .CNT_W(CNT_W)) shift_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (run_w),
        .load_i      (load_w),
        .load_word_i (load_word),
        .load_len_i  (load_len),
        .bit_o       (bit_w),
        .last_o      (last_w)
    );

    // Purpose: drive the line, idle level until aligned.
    assign txd_o = run_w ? bit_w : cfg_idle_ones_i;

endmodule

// File: rtl/rxlock_sync_tx_chk.sv
// Module: assertion checker bound to the transmitter top.
// It keeps its own count of the wait cycles and checks the alignment timing,
// the permanence of alignment and the handshake.
module rxlock_sync_tx_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [1:0]  cfg_sync_len_i,
    input logic [15:0] cfg_sync_pat_i,
    input logic        hunt_exit_i,
    input logic        tx_valid_i,
    input logic        tx_ready_o,
    input logic        txd_o,
    input logic        waiting_i,
    input logic        running_i
);

    logic [5:0] wait_cnt_q;
    logic [5:0] exp_len;

    // Purpose: count the clocks spent between hunt-exit and the start of the run.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wait_cnt_q <= '0;
        end else if (!running_i && !waiting_i && hunt_exit_i) begin
            wait_cnt_q <= '0;
        end else if (waiting_i) begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    // Purpose: expected length, derived separately from the length codes.
    always_comb begin
        case (cfg_sync_len_i)
            2'b00:   exp_len = 6'd6;
            2'b10:   exp_len = 6'd16;
            default: exp_len = 6'd8;
        endcase
    end

    // R3, R4: the run starts exactly one sync length after hunt-exit
    p_delay_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_i) |-> (wait_cnt_q == exp_len));

    // R3: the wait never falls back to hunting
    p_wait_progress_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        waiting_i |=> (waiting_i || running_i));

    // R5: the first bit sent is bit 0 of the sync pattern
    p_first_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_i) |-> (txd_o == cfg_sync_pat_i[0]));

    // R8: alignment persists until reset
    p_stay_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_i |=> running_i);

    // R8: a new pulse while running does not restart the wait
    p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && hunt_exit_i) |=> !waiting_i);

    // R9: an accepted byte fills the holding register
    p_ready_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

endmodule

bind rxlock_sync_tx rxlock_sync_tx_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_sync_len_i (cfg_sync_len_i),
    .cfg_sync_pat_i (cfg_sync_pat_i),
    .hunt_exit_i    (hunt_exit_i),
    .tx_valid_i     (tx_valid_i),
    .tx_ready_o     (tx_ready_o),
    .txd_o          (txd_o),
    .waiting_i      (wait_w),
    .running_i      (run_w)
);

// File: tb/rxlock_sync_tx_tb_top.sv
`timescale 1ns/1ps
module rxlock_sync_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        idle_ones;
    logic [1:0]  len_code;
    logic [15:0] sync_pat;
    logic        hunt_exit;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        txd;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] feed [4];
    bit exp_b [128];
    bit act_b [128];

    // Vector fields: [26:25] length code, [24] idle level, [23:8] pattern, [7:0] data byte
    localparam logic [26:0] VEC [6] = '{
        {2'd0, 1'b1, 16'h0026, 8'hA5},
        {2'd1, 1'b0, 16'h0016, 8'h3C},
        {2'd2, 1'b1, 16'hB25E, 8'h81},
        {2'd3, 1'b0, 16'h007E, 8'hFF},
        {2'd1, 1'b1, 16'h00F0, 8'h00},
        {2'd2, 1'b0, 16'h1234, 8'h5A}
    };

    always #2 clk = ~clk;

    rxlock_sync_tx dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cfg_idle_ones_i (idle_ones),
        .cfg_sync_len_i  (len_code),
        .cfg_sync_pat_i  (sync_pat),
        .hunt_exit_i     (hunt_exit),
        .tx_data_i       (tx_data),
        .tx_valid_i      (tx_valid),
        .tx_ready_o      (tx_ready),
        .txd_o           (txd)
    );

    function automatic int len_of(input logic [1:0] code);
        case (code)
            2'd0:    return 6;
            2'd2:    return 16;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        hunt_exit = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Expected stream: L idle cycles, one sync, the bytes, then sync fill.
    function automatic void build_exp(input int L, input bit idle, input logic [15:0] pat,
                                      input int nbytes, input int nsamp);
        int p = 0;
        for (int i = 0; i < L; i++) begin exp_b[p] = idle; p++; end
        for (int i = 0; i < L; i++) begin exp_b[p] = pat[i]; p++; end
        for (int b = 0; b < nbytes; b++)
            for (int k = 0; k < 8; k++) begin exp_b[p] = feed[b][k]; p++; end
        while (p < nsamp) begin
            for (int i = 0; i < L; i++)
                if (p < nsamp) begin exp_b[p] = pat[i]; p++; end
        end
    endfunction

    // Pulse hunt-exit at this negedge, sample txd each following negedge, feed bytes when ready.
    task automatic run_capture(input int nsamp, input int nbytes, input int rp_a, input int rp_b);
        int fed = 0;
        hunt_exit = 1'b1;
        if (nbytes > 0 && tx_ready) begin tx_valid = 1'b1; tx_data = feed[0]; fed = 1; end
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            act_b[i]  = txd;
            hunt_exit = (i == rp_a) || (i == rp_b);
            tx_valid  = 1'b0;
            if (fed < nbytes && tx_ready) begin
                tx_valid = 1'b1;
                tx_data  = feed[fed];
                fed++;
            end
        end
        hunt_exit = 1'b0;
        tx_valid  = 1'b0;
    endtask

    task automatic check_stream(input string req, input int nsamp);
        int bad = -1;
        for (int i = 0; i < nsamp; i++)
            if (bad < 0 && act_b[i] != exp_b[i]) bad = i;
        n_checks++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: bit %0d actual %0b expected %0b", req, bad, act_b[bad], exp_b[bad]);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_ones = 1'b1;
        len_code  = 2'd1;
        sync_pat  = 16'h0016;
        rst_n     = 1'b0;
        hunt_exit = 1'b0;
        tx_valid  = 1'b0;
        tx_data   = '0;

        // Vector table: R1, R3, R4, R5, R6, R7 per length code and idle level
        for (int v = 0; v < 6; v++) begin
            int L;
            len_code  = VEC[v][26:25];
            idle_ones = VEC[v][24];
            sync_pat  = VEC[v][23:8];
            feed[0]   = VEC[v][7:0];
            L         = len_of(len_code);
            do_reset();
            check("R1 reset txd", txd, idle_ones);
            check("R1 reset ready", tx_ready, 1'b1);
            build_exp(L, idle_ones, sync_pat, 1, 3 * L + 8);
            run_capture(3 * L + 8, 1, -1, -1);
            check_stream("R3 R4 R5 R6 R7 vector stream", 3 * L + 8);
        end

        // R2: idle level held while hunting, even with a byte queued
        idle_ones = 1'b1;
        len_code  = 2'd1;
        sync_pat  = 16'h0016;
        do_reset();
        tx_valid = 1'b1;
        tx_data  = 8'h99;
        @(negedge clk);
        tx_valid = 1'b0;
        begin
            bit all_one = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) all_one = 1'b0;
            end
            check("R2 idle ones while hunting", all_one, 1'b1);
        end
        idle_ones = 1'b0;
        #1;
        check("R2 idle zeros while hunting", txd, 1'b0);

        // R8: extra hunt-exit pulses during the wait and during the run
        idle_ones = 1'b0;
        len_code  = 2'd1;
        sync_pat  = 16'h00B4;
        do_reset();
        build_exp(8, 1'b0, sync_pat, 0, 48);
        run_capture(48, 0, 3, 30);
        check_stream("R8 R7 pulses ignored", 48);

        // R9: ready falls when full, a second byte offered then is dropped
        idle_ones = 1'b1;
        len_code  = 2'd0;
        sync_pat  = 16'h0019;
        do_reset();
        tx_valid = 1'b1;
        tx_data  = 8'hC3;
        @(negedge clk);
        tx_valid = 1'b0;
        check("R9 ready low when full", tx_ready, 1'b0);
        tx_valid = 1'b1;
        tx_data  = 8'h5A;
        repeat (3) @(negedge clk);
        tx_valid = 1'b0;
        feed[0]  = 8'hC3;
        build_exp(6, 1'b1, sync_pat, 1, 32);
        run_capture(32, 0, -1, -1);
        check_stream("R9 R6 single byte sent once", 32);
        check("R9 ready high after send", tx_ready, 1'b1);

        // R6 R7: back-to-back bytes with 6-bit sync, then sync fill
        idle_ones = 1'b0;
        len_code  = 2'd0;
        sync_pat  = 16'h002D;
        feed[0]   = 8'h6E;
        feed[1]   = 8'h01;
        feed[2]   = 8'hF7;
        do_reset();
        build_exp(6, 1'b0, sync_pat, 3, 54);
        run_capture(54, 3, -1, -1);
        check_stream("R6 R7 back-to-back bytes", 54);

        // R4: 16-bit sync with two bytes, no gaps
        idle_ones = 1'b1;
        len_code  = 2'd2;
        sync_pat  = 16'h8E31;
        feed[0]   = 8'h55;
        feed[1]   = 8'hAA;
        do_reset();
        build_exp(16, 1'b1, sync_pat, 2, 64);
        run_capture(64, 2, -1, -1);
        check_stream("R4 R6 16-bit sync with bytes", 64);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule